// File: doc/BRIEF.md
# Bit-Oriented Message Codeword Detector

This block watches a serial data-link bit stream for repeating bit-oriented messages and pulls the 6-bit codeword out of them. A message is a 16-bit frame that is sent over and over. It starts with eight 1s, then a 0, then six codeword bits, then a closing 0. The detector keeps a sliding 16-bit window over the incoming bits. That frame shape can line up at only one bit position, so the block locks onto it without a separate alignment step.

A codeword is reported valid once the same frame has arrived on a set number of back-to-back 16-bit repetitions, three by default. Validity is withdrawn as soon as a frame fails to repeat. A one-cycle interrupt marks a codeword that becomes valid and differs from the last one reported. Detection runs all the time, whatever the surrounding framed traffic is doing, so a message that cuts into a frame in progress is still picked up.

Top module: `bom_detect`

## Requirements
- R1: After reset, `valid_o` and `irq_o` are 0 and `code_o` is 0. This also holds after a reset applied while a codeword is valid.
- R2: A frame is the sequence eight 1s, 0, C5..C0, 0 in arrival order. The first codeword bit to arrive becomes bit 5 of `code_o`.
- R3: `valid_o` rises only after a set number of identical frames arrive back to back, each 16 bits after the previous one (default 3). Two repetitions are not enough.
- R4: Once valid, `valid_o` stays high for the first 15 bits after a frame that do not complete a new frame. It drops on the 16th such bit, for example when idle 0x7E flags follow.
- R5: A frame with a different codeword restarts the repetition count and drops `valid_o`. While `valid_o` stays high, `code_o` does not change.
- R6: `irq_o` is a single-cycle pulse, issued together with `valid_o` rising, when the newly valid codeword differs from the last one reported. The first codeword that becomes valid after reset always raises it.
- R7: When the same codeword becomes valid again after validity was lost, `valid_o` rises without an `irq_o` pulse.
- R8: A message is recognised directly after arbitrary framed traffic (flags and data bytes) with no separator in between.
- R9: Bits are taken only in cycles where `bit_en_i` is 1. Idle cycles between enabled bits change neither the result nor the outputs.
- R10: A single differing frame in the middle of a run breaks the repetition. Identical frames before and after it do not add up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_i | input | 1 | Serial data-link bit |
| bit_en_i | input | 1 | Qualifies `bit_i` for this cycle |
| code_o | output | 6 | Last codeword reported valid |
| valid_o | output | 1 | A codeword is currently confirmed by repetition |
| irq_o | output | 1 | One-cycle pulse when a new differing codeword becomes valid |

## Verification
The stimulus table sends bursts of each codeword with fixed repetition counts, separated by 0x7E flags. These bursts separate a run that is one frame short of the threshold from one that meets it, and a repeat of the same code from a new code. Asymmetric codewords expose a reversed bit order. Directed runs probe the 15-bit and 16-bit break boundary, a code change within a run, and a single stray frame splitting two partial runs. Further runs cover a message arriving right after data bytes, bits spaced out by idle cycles, and a reset taken while a codeword is valid.

// File: rtl/bom_pkg.sv
package bom_pkg;
   localparam int unsigned FLAG_LEN_DEF = 8;
   localparam int unsigned CODE_W_DEF   = 6;
   localparam int unsigned REPEATS_DEF  = 3;

   // flag run, leading zero, codeword, trailing zero
   function automatic int unsigned frame_bits(int unsigned flag_len, int unsigned code_w);
      return flag_len + code_w + 2;
   endfunction
endpackage

// File: rtl/bom_window.sv
module bom_window #(
   parameter int unsigned FRAME_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bit_i,
   input  logic               bit_en_i,
   output logic [FRAME_W-1:0] win_o,
   output logic               fresh_o
);
   if (FRAME_W < 4) begin : g_bad_width
      $error("bom_window: FRAME_W too small");
   end

   logic [FRAME_W-1:0] win_q;
   logic               fresh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q   <= '0;
         fresh_q <= 1'b0;
      end else begin
         fresh_q <= bit_en_i;
         if (bit_en_i) begin
            win_q <= {win_q[FRAME_W-2:0], bit_i};
         end
      end
   end

   assign win_o   = win_q;
   assign fresh_o = fresh_q;
endmodule

// File: rtl/bom_frame_match.sv
module bom_frame_match #(
   parameter int unsigned FLAG_LEN       = 8,
   parameter int unsigned CODE_W         = 6,
   parameter bit          CODE_MSB_FIRST = 1'b1,
   localparam int unsigned FRAME_W       = FLAG_LEN + CODE_W + 2
) (
   input  logic [FRAME_W-1:0] win_i,
   output logic               hit_o,
   output logic [CODE_W-1:0]  code_o
);
   // a flag run longer than the codeword keeps the alignment unique
   if (FLAG_LEN <= CODE_W) begin : g_bad_flag
      $error("bom_frame_match: FLAG_LEN must exceed CODE_W");
   end

   logic [CODE_W-1:0] raw;
   assign raw   = win_i[CODE_W:1];
   assign hit_o = (&win_i[FRAME_W-1 -: FLAG_LEN]) & ~win_i[CODE_W+1] & ~win_i[0];

   if (CODE_MSB_FIRST) begin : g_msb_first
      assign code_o = raw;
   end else begin : g_lsb_first
      for (genvar i = 0; i < CODE_W; i++) begin : g_rev
         assign code_o[i] = raw[CODE_W-1-i];
      end
   end
endmodule

// File: rtl/bom_qualify.sv
module bom_qualify #(
   parameter int unsigned CODE_W  = 6,
   parameter int unsigned FRAME_W = 16,
   parameter int unsigned REPEATS = 3,
   localparam int unsigned GAP_W  = $clog2(FRAME_W),
   localparam int unsigned CNT_W  = $clog2(REPEATS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fresh_i,
   input  logic              hit_i,
   input  logic [CODE_W-1:0] code_i,
   output logic              valid_o,
   output logic [CODE_W-1:0] code_o,
   output logic              irq_o
);
   if (REPEATS < 2) begin : g_bad_rep
      $error("bom_qualify: REPEATS must be at least 2");
   end

   localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(FRAME_W - 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(REPEATS);

   logic [GAP_W-1:0]  gap_q;
   logic [CNT_W-1:0]  cnt_q, cnt_hit;
   logic [CODE_W-1:0] cand_q, rep_q;
   logic              seen_q, irq_q, same;

   always_comb begin
      same    = (cnt_q != '0) && (gap_q == GAP_LAST) && (code_i == cand_q);
      cnt_hit = !same ? CNT_W'(1) : (cnt_q == CNT_FULL) ? cnt_q : cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         gap_q  <= GAP_LAST;
         cnt_q  <= '0;
         cand_q <= '0;
         rep_q  <= '0;
         seen_q <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= 1'b0;
         if (fresh_i) begin
            if (hit_i) begin
               gap_q  <= '0;
               cnt_q  <= cnt_hit;
               cand_q <= code_i;
               if (cnt_hit == CNT_FULL) begin
                  rep_q  <= code_i;
                  seen_q <= 1'b1;
                  if (cnt_q != CNT_FULL && (!seen_q || code_i != rep_q)) begin
                     irq_q <= 1'b1;
                  end
               end
            end else if (gap_q != GAP_LAST) begin
               gap_q <= gap_q + GAP_W'(1);
            end else begin
               cnt_q <= '0;
            end
         end
      end
   end

   assign valid_o = (cnt_q == CNT_FULL);
   assign code_o  = rep_q;
   assign irq_o   = irq_q;

   p_irq_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);
   p_irq_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> valid_o);
   p_valid_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(valid_o) |-> $past(fresh_i && hit_i));
   p_valid_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(valid_o) |-> $past(fresh_i));
   p_code_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && $past(valid_o)) |-> $stable(code_o));
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !fresh_i |=> ($stable(valid_o) && $stable(code_o) && !irq_o));
endmodule

// File: rtl/bom_detect.sv
module bom_detect #(
   parameter int unsigned FLAG_LEN       = bom_pkg::FLAG_LEN_DEF,
   parameter int unsigned CODE_W         = bom_pkg::CODE_W_DEF,
   parameter int unsigned REPEATS        = bom_pkg::REPEATS_DEF,
   parameter bit          CODE_MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_i,
   input  logic              bit_en_i,
   output logic [CODE_W-1:0] code_o,
   output logic              valid_o,
   output logic              irq_o
);
   localparam int unsigned FRAME_W = bom_pkg::frame_bits(FLAG_LEN, CODE_W);

   logic [FRAME_W-1:0] win;
   logic               fresh, hit;
   logic [CODE_W-1:0]  code_now;

   bom_window #(.FRAME_W(FRAME_W)) u_window (
      .clk(clk), .rst_n(rst_n), .bit_i(bit_i), .bit_en_i(bit_en_i),
      .win_o(win), .fresh_o(fresh)
   );

   bom_frame_match #(.FLAG_LEN(FLAG_LEN), .CODE_W(CODE_W),
                     .CODE_MSB_FIRST(CODE_MSB_FIRST)) u_match (
      .win_i(win), .hit_o(hit), .code_o(code_now)
   );

   bom_qualify #(.CODE_W(CODE_W), .FRAME_W(FRAME_W), .REPEATS(REPEATS)) u_qualify (
      .clk(clk), .rst_n(rst_n), .fresh_i(fresh), .hit_i(hit), .code_i(code_now),
      .valid_o(valid_o), .code_o(code_o), .irq_o(irq_o)
   );
endmodule

// File: tb/bom_detect_bench.sv
`timescale 1ns/1ps
module bom_detect_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_i = 1'b0;
   logic       bit_en_i = 1'b0;
   logic [5:0] code_o;
   logic       valid_o, irq_o;

   int n_chk = 0, n_bad = 0, irq_cnt = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   bom_detect u_bom_detect (
      .clk(clk), .rst_n(rst_n), .bit_i(bit_i), .bit_en_i(bit_en_i),
      .code_o(code_o), .valid_o(valid_o), .irq_o(irq_o)
   );

   always @(negedge clk) if (irq_o) irq_cnt++;

   typedef struct packed {
      logic [5:0] code;
      logic [3:0] reps;
      logic       val;
      logic [1:0] irqs;
   } vec_t;

   localparam vec_t VEC [7] = '{
      '{6'h13, 4'd2,  1'b0, 2'd0},   // R3 one short
      '{6'h13, 4'd3,  1'b1, 2'd1},   // R3 threshold, R6 first
      '{6'h13, 4'd5,  1'b1, 2'd0},   // R7 same code again
      '{6'h3F, 4'd4,  1'b1, 2'd1},
      '{6'h00, 4'd3,  1'b1, 2'd1},
      '{6'h2A, 4'd1,  1'b0, 2'd0},
      '{6'h0B, 4'd10, 1'b1, 2'd1}
   };

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      bit_i = b;
      bit_en_i = 1'b1;
   endtask

   task automatic send_bit_slow(input logic b);
      send_bit(b);
      @(negedge clk);
      bit_en_i = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic idle(input int n);
      @(negedge clk);
      bit_en_i = 1'b0;
      repeat (n - 1) @(negedge clk);
   endtask

   task automatic send_byte(input logic [7:0] b);
      for (int i = 7; i >= 0; i--) send_bit(b[i]);
   endtask

   task automatic send_frame(input logic [5:0] c, input bit slow);
      logic [15:0] f;
      f = {8'hFF, 1'b0, c, 1'b0};
      for (int i = 15; i >= 0; i--) begin
         if (slow) send_bit_slow(f[i]);
         else send_bit(f[i]);
      end
   endtask

   task automatic flags();
      repeat (3) send_byte(8'h7E);
   endtask

   task automatic expect_state(input logic v, input logic [5:0] c, input string req);
      check(valid_o == v, {req, " valid"}, valid_o, v);
      if (v) check(code_o == c, {req, " code"}, code_o, c);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check(valid_o == 1'b0 && irq_o == 1'b0 && code_o == 6'h00, "R1", {code_o, valid_o, irq_o}, 0);
      rst_n = 1'b1;
      idle(2);
      check(valid_o == 1'b0 && irq_o == 1'b0, "R1", {valid_o, irq_o}, 0);

      // table walk: R2, R3, R6, R7
      for (int i = 0; i < 7; i++) begin
         int base;
         flags();
         base = irq_cnt;
         for (int r = 0; r < int'(VEC[i].reps); r++) send_frame(VEC[i].code, 1'b0);
         idle(4);
         expect_state(VEC[i].val, VEC[i].code, "R2/R3");
         check(irq_cnt - base == int'(VEC[i].irqs), "R6/R7 irq count", irq_cnt - base, VEC[i].irqs);
      end

      // R4: 15 stray bits keep valid, the 16th drops it (code 0B still valid here)
      begin
         logic [15:0] s;
         s = 16'h7E7E;
         for (int i = 15; i >= 1; i--) send_bit(s[i]);
         idle(4);
         expect_state(1'b1, 6'h0B, "R4 after 15 bits");
         send_bit(s[0]);
         idle(4);
         expect_state(1'b0, 6'h0B, "R4 after 16 bits");
      end

      // R5: code change inside a run
      begin
         int base;
         flags();
         base = irq_cnt;
         repeat (3) send_frame(6'h21, 1'b0);
         idle(4);
         expect_state(1'b1, 6'h21, "R5 first code");
         send_frame(6'h1C, 1'b0);
         idle(4);
         expect_state(1'b0, 6'h21, "R5 change drops");
         repeat (2) send_frame(6'h1C, 1'b0);
         idle(4);
         expect_state(1'b1, 6'h1C, "R5 new code");
         check(irq_cnt - base == 2, "R5/R6 irq count", irq_cnt - base, 2);
      end

      // R10: stray frame splits the run
      begin
         flags();
         repeat (2) send_frame(6'h05, 1'b0);
         send_frame(6'h06, 1'b0);
         repeat (2) send_frame(6'h05, 1'b0);
         idle(4);
         expect_state(1'b0, 6'h05, "R10 split run");
         send_frame(6'h05, 1'b0);
         idle(4);
         expect_state(1'b1, 6'h05, "R10 completed run");
      end

      // R8: message right after data bytes
      begin
         send_byte(8'h7E);
         send_byte(8'h5A);
         send_byte(8'hC3);
         repeat (3) send_frame(6'h31, 1'b0);
         idle(4);
         expect_state(1'b1, 6'h31, "R8 after data");
      end

      // R9: spaced bits
      begin
         int base;
         flags();
         base = irq_cnt;
         repeat (2) send_frame(6'h2D, 1'b1);
         idle(4);
         expect_state(1'b0, 6'h2D, "R9 two spaced frames");
         send_frame(6'h2D, 1'b1);
         idle(6);
         expect_state(1'b1, 6'h2D, "R9 spaced frames");
         check(irq_cnt - base == 1, "R9 irq count", irq_cnt - base, 1);
      end

      // R1 reset while valid, then R6 first code after reset
      begin
         int base;
         @(negedge clk);
         rst_n = 1'b0;
         idle(2);
         check(valid_o == 1'b0 && irq_o == 1'b0 && code_o == 6'h00, "R1 mid-run reset",
               {code_o, valid_o, irq_o}, 0);
         rst_n = 1'b1;
         base = irq_cnt;
         repeat (3) send_frame(6'h2D, 1'b0);
         idle(4);
         expect_state(1'b1, 6'h2D, "R6 after reset");
         check(irq_cnt - base == 1, "R6 irq after reset", irq_cnt - base, 1);
      end

      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule